// File: doc/BRIEF.md
# Configurable-Timing SPI Serial Engine

This block is the master-side shift engine of a serial peripheral port. It accepts one parallel word at a time from a transmit source and sends it out on a data-out line. It drives a serial bit clock and a frame-select line, samples the data-in line, and returns the received word. All of this runs from one system clock. The bit clock is derived from that clock through an even divider.

The clocking is not picked from a two-bit mode number. Four independent controls set it:
- which serial clock edge samples data-in;
- the level the serial clock rests at;
- whether the first clock edge is held back after the frame opens;
- whether the frame opens on a rising or a falling bit-clock edge.

The last control decides the length of the hold-back: a full bit time or half a bit time. Frame-select polarity, bit order and word length (1 to 32 bits) are also set per word. All controls are captured when a word is accepted. A busy output marks the word in flight. Dropping the enable input abandons the word at once.

Timing model, in half bit-times H:
- The frame opens on the cycle a word is accepted.
- The first serial clock edge follows after lead halves. The lead is 1 with no delay, 2 with the delay and a falling frame-start edge, and 3 with the delay and a rising frame-start edge.
- After that the clock toggles once per half bit-time, 2N times in all.
- One more half bit-time later the frame closes.

Top module: `spi_frame_engine`

## Requirements
- R1: The half bit-time is cfg_div/2 system cycles, with cfg_div values 0 and 1 treated as 2. A word of N bits with lead L keeps the frame active for exactly H*(L+2N) cycles.
- R2: While no word is in flight, sclk rests at cfg_idle_high (0 = low, 1 = high) from the cycle after the control is sampled.
- R3: The first serial clock edge comes H*L cycles after the frame opens. L is 1 when cfg_start_dly=0, 2 when cfg_start_dly=1 with cfg_start_fall=1, and 3 when cfg_start_dly=1 with cfg_start_fall=0.
- R4: miso is sampled on rising sclk edges when cfg_cap_fall=0 and on falling edges when it is 1. mosi changes only on the other edge type, and only after the first sample, so every bit is stable across the edge that samples it.
- R5: fsel is at cfg_frame_high while a word is in flight and at its complement otherwise.
- R6: cfg_len gives the word length N. A value of 0 means 1 and values above 32 mean 32. With cfg_lsb_first=0, tx_data[N-1] goes out first; with 1, tx_data[0] goes out first. Bits of tx_data above N-1 are not sent.
- R7: rx_data is right-aligned. The first received bit lands in bit N-1 for MSB-first and in bit 0 for LSB-first, and bits N..31 are zero.
- R8: tx_ready is high exactly when enable is high and no word is in flight. A word is taken when tx_valid and tx_ready are both high, and busy is high from the next cycle until the word ends.
- R9: While enable is low no word is accepted. If enable drops during a word, the cycle after it is sampled low shows busy low, fsel inactive and sclk at idle, and that word never produces rx_valid.
- R10: rx_valid is a one-cycle pulse in the same cycle that busy falls and fsel closes at the end of a completed word.
- R11: Each word produces exactly 2N serial clock edges, and sclk ends at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable; low aborts a word in flight |
| cfg_div | input | 8 | Bit clock ratio in system cycles (even; 0 and 1 act as 2) |
| cfg_cap_fall | input | 1 | Sampling edge: 0 rising, 1 falling |
| cfg_idle_high | input | 1 | Resting level of sclk |
| cfg_start_dly | input | 1 | Hold back the first clock edge after the frame opens |
| cfg_start_fall | input | 1 | Frame-start edge: 0 rising (full-bit hold-back), 1 falling (half-bit) |
| cfg_frame_high | input | 1 | Active level of fsel |
| cfg_lsb_first | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| cfg_len | input | 6 | Bits per word |
| tx_valid | input | 1 | A transmit word is offered |
| tx_data | input | 32 | Transmit word, right-aligned |
| tx_ready | output | 1 | Engine can take a word this cycle |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| rx_data | output | 32 | Received word, right-aligned, upper bits zero |
| busy | output | 1 | A word is in flight |
| sclk | output | 1 | Serial bit clock |
| fsel | output | 1 | Frame/select line |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench goes after the mapping of the four timing controls. It covers all four conventional mode settings plus a half-bit hold-back. A design that mixed up the hold-back length would show a first-edge distance off by one half bit-time. A design that sampled on the wrong edge would return a word shifted by one bit or taken from stale data.

Divider values 0 and 1 are exercised: treating them literally would stall the timer or run it at the wrong rate, and the frame length would be off. Lengths 0, 1, 32 and 40 are exercised too: a design without clamping would emit the wrong number of clock edges or leak unused upper bits into rx_data. Finally, enable is dropped in mid-word; a design that finished the word anyway would keep busy high and later raise rx_valid.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  typedef enum logic {
    SEQ_IDLE   = 1'b0,
    SEQ_ACTIVE = 1'b1
  } seq_state_e;

  // Per-word mode bits captured at acceptance.
  typedef struct packed {
    logic cap_fall;
    logic idle_high;
    logic lsb_first;
  } word_mode_t;

  // Number of half bit-times from frame open to the first clock edge.
  function automatic logic [1:0] lead_halves(input logic delay_on, input logic start_fall);
    if (!delay_on) begin
      return 2'd1;
    end
    return start_fall ? 2'd2 : 2'd3;
  endfunction

endpackage

// File: rtl/sfe_halfbit.sv
module sfe_halfbit #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_len,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q == (half_len - 1'b1));
  assign tick = run && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sfe_seq.sv
module sfe_seq
  import sfe_pkg::*;
#(
  parameter int unsigned LEN_W = 6,
  parameter int unsigned PH_W  = LEN_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic             tick,
  input  logic [1:0]       lead,
  input  logic [LEN_W-1:0] nbits,
  input  logic             cap_fall,
  input  logic             idle_high,
  output logic             active,
  output logic             sclk,
  output logic             cap_pulse,
  output logic             shift_pulse,
  output logic             done_pulse
);

  seq_state_e      st_q, st_d;
  logic [PH_W-1:0] ph_q, ph_d, ph_inc, edge_lo, edge_end;
  logic            sclk_q, sclk_d;
  logic            in_edge, at_end, is_act;

  assign is_act   = (st_q == SEQ_ACTIVE);
  assign ph_inc   = ph_q + 1'b1;
  assign edge_lo  = PH_W'(lead);
  assign edge_end = PH_W'(lead) + (PH_W'(nbits) << 1);
  assign in_edge  = is_act && tick && (ph_inc >= edge_lo) && (ph_inc < edge_end);
  assign at_end   = is_act && tick && (ph_inc == edge_end);

  // A sampling edge is one that leaves the level equal to cap_fall.
  assign cap_pulse   = enable && in_edge && (sclk_q == cap_fall);
  assign shift_pulse = enable && in_edge && (sclk_q != cap_fall);
  assign done_pulse  = enable && at_end;

  assign active = is_act;
  assign sclk   = sclk_q;

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    sclk_d = sclk_q;
    if (!is_act) begin
      sclk_d = idle_high;
      ph_d   = '0;
      if (start) begin
        st_d = SEQ_ACTIVE;
      end
    end else if (!enable || at_end) begin
      st_d   = SEQ_IDLE;
      ph_d   = '0;
      sclk_d = idle_high;
    end else if (tick) begin
      ph_d = ph_inc;
      if (in_edge) begin
        sclk_d = ~sclk_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      sclk_q <= sclk_d;
    end
  end

endmodule

// File: rtl/sfe_shift.sv
module sfe_shift #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [LEN_W-1:0]  nbits,
  input  logic              lsb_first,
  input  logic              cap_pulse,
  input  logic              shift_pulse,
  input  logic              done_pulse,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);

  localparam int unsigned SH_W = $clog2(WORD_W) + 1;

  logic [SH_W-1:0]   gap;
  logic [WORD_W-1:0] tx_q, tx_d, rx_q, rx_d, rxo_q, rx_final;
  logic              seen_q, seen_d, rv_q;
  logic              tx_en, rx_en;

  assign gap      = SH_W'(WORD_W) - SH_W'(nbits);
  assign rx_final = lsb_first ? (rx_q >> gap) : rx_q;
  assign mosi     = lsb_first ? tx_q[0] : tx_q[WORD_W-1];

  assign tx_en = load || (shift_pulse && seen_q);
  assign rx_en = load || cap_pulse;

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    seen_d = seen_q;
    if (load) begin
      tx_d   = lsb_first ? tx_word : (tx_word << gap);
      rx_d   = '0;
      seen_d = 1'b0;
    end else begin
      if (shift_pulse && seen_q) begin
        tx_d = lsb_first ? (tx_q >> 1) : (tx_q << 1);
      end
      if (cap_pulse) begin
        seen_d = 1'b1;
        rx_d   = lsb_first ? {miso, rx_q[WORD_W-1:1]} : {rx_q[WORD_W-2:0], miso};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      seen_q <= 1'b0;
    end else begin
      if (tx_en) begin
        tx_q <= tx_d;
      end
      if (rx_en) begin
        rx_q   <= rx_d;
        seen_q <= seen_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxo_q <= '0;
      rv_q  <= 1'b0;
    end else begin
      rv_q <= done_pulse;
      if (done_pulse) begin
        rxo_q <= rx_final;
      end
    end
  end

  assign rx_word  = rxo_q;
  assign rx_valid = rv_q;

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import sfe_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LEN_W  = 6,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_cap_fall,
  input  logic              cfg_idle_high,
  input  logic              cfg_start_dly,
  input  logic              cfg_start_fall,
  input  logic              cfg_frame_high,
  input  logic              cfg_lsb_first,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              busy,
  output logic              sclk,
  output logic              fsel,
  output logic              mosi,
  input  logic              miso
);

  localparam int unsigned PH_W = LEN_W + 3;

  logic [DIV_W-1:0] half_live, half_q, half_cur;
  logic [LEN_W-1:0] n_live, n_q, n_cur;
  logic [1:0]       lead_live, lead_q, lead_cur;
  word_mode_t       mode_live, mode_q, mode_cur;
  logic             accept, active, tick;
  logic             cap_pulse, shift_pulse, done_pulse, dp_mosi;

  // Effective settings derived from the live controls.
  assign half_live = (cfg_div < DIV_W'(2)) ? DIV_W'(1) : (cfg_div >> 1);
  assign n_live    = (cfg_len == '0) ? LEN_W'(1) :
                     (cfg_len > LEN_W'(WORD_W)) ? LEN_W'(WORD_W) : cfg_len;
  assign lead_live = lead_halves(cfg_start_dly, cfg_start_fall);
  assign mode_live = '{cap_fall: cfg_cap_fall, idle_high: cfg_idle_high,
                       lsb_first: cfg_lsb_first};

  assign accept   = !active && enable && tx_valid;
  assign tx_ready = !active && enable;

  // Settings in force: live while idle (used on the accepting edge), held while busy.
  assign half_cur = active ? half_q : half_live;
  assign n_cur    = active ? n_q    : n_live;
  assign lead_cur = active ? lead_q : lead_live;
  assign mode_cur = active ? mode_q : mode_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      n_q    <= '0;
      lead_q <= '0;
      mode_q <= '0;
    end else if (accept) begin
      half_q <= half_live;
      n_q    <= n_live;
      lead_q <= lead_live;
      mode_q <= mode_live;
    end
  end

  sfe_halfbit #(.DIV_W(DIV_W)) u_halfbit (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (active),
    .half_len (half_cur),
    .tick     (tick)
  );

  sfe_seq #(.LEN_W(LEN_W), .PH_W(PH_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .start       (accept),
    .tick        (tick),
    .lead        (lead_cur),
    .nbits       (n_cur),
    .cap_fall    (mode_cur.cap_fall),
    .idle_high   (mode_cur.idle_high),
    .active      (active),
    .sclk        (sclk),
    .cap_pulse   (cap_pulse),
    .shift_pulse (shift_pulse),
    .done_pulse  (done_pulse)
  );

  sfe_shift #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .tx_word     (tx_data),
    .nbits       (n_cur),
    .lsb_first   (mode_cur.lsb_first),
    .cap_pulse   (cap_pulse),
    .shift_pulse (shift_pulse),
    .done_pulse  (done_pulse),
    .miso        (miso),
    .mosi        (dp_mosi),
    .rx_word     (rx_data),
    .rx_valid    (rx_valid)
  );

  assign busy = active;
  assign fsel = active ? cfg_frame_high : ~cfg_frame_high;
  assign mosi = active & dp_mosi;

endmodule

// File: rtl/sfe_checker.sv
module sfe_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic tx_valid,
  input logic tx_ready,
  input logic busy,
  input logic rx_valid,
  input logic sclk,
  input logic cfg_idle_high
);

  AST_RXV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R10

  AST_RXV_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!busy && $past(busy))); // R10

  AST_ABORT_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !enable) |=> (!busy && !rx_valid)); // R9

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> busy); // R8

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(tx_valid && tx_ready)) |=> (sclk == $past(cfg_idle_high))); // R2

endmodule

bind spi_frame_engine sfe_checker u_sfe_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .busy          (busy),
  .rx_valid      (rx_valid),
  .sclk          (sclk),
  .cfg_idle_high (cfg_idle_high)
);

// File: tb/test_spi_frame_engine.sv
`timescale 1ns/1ps
module test_spi_frame_engine;

  typedef struct packed {
    logic [7:0]  div;
    logic        cap;
    logic        idle;
    logic        dly;
    logic        sf;
    logic        fp;
    logic        lsb;
    logic [5:0]  len;
    logic [31:0] tx;
    logic [31:0] sw;
  } vec_t;

  // div, cap, idle, dly, sf, fp, lsb, len, tx, slave word
  localparam vec_t VECS [8] = '{
    '{8'd4,   1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd8,  32'h0000_00A5, 32'h0000_003C},
    '{8'd6,   1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'd8,  32'h0000_01B6, 32'hFFFF_FFC4},
    '{8'd2,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'd12, 32'hABCD_E9F1, 32'h0000_0A53},
    '{8'd8,   1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd16, 32'h5555_C3A1, 32'h1234_8E17},
    '{8'd0,   1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd32, 32'hDEAD_BEEF, 32'hC001_D00D},
    '{8'd1,   1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 6'd0,  32'hFFFF_FFFF, 32'h0000_0001},
    '{8'd10,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'd40, 32'h8000_0001, 32'h7E5A_A5E7},
    '{8'd254, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'd3,  32'h0000_0006, 32'hFFFF_FFF5}
  };

  logic        clk, rst_n, enable;
  logic [7:0]  cfg_div;
  logic        cfg_cap_fall, cfg_idle_high, cfg_start_dly, cfg_start_fall;
  logic        cfg_frame_high, cfg_lsb_first;
  logic [5:0]  cfg_len;
  logic        tx_valid, tx_ready, rx_valid, busy, sclk, fsel, mosi, miso;
  logic [31:0] tx_data, rx_data;

  int total = 0;
  int bad   = 0;

  spi_frame_engine i_spi_frame_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_div(cfg_div),
    .cfg_cap_fall(cfg_cap_fall), .cfg_idle_high(cfg_idle_high),
    .cfg_start_dly(cfg_start_dly), .cfg_start_fall(cfg_start_fall),
    .cfg_frame_high(cfg_frame_high), .cfg_lsb_first(cfg_lsb_first),
    .cfg_len(cfg_len), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .busy(busy), .sclk(sclk), .fsel(fsel), .mosi(mosi), .miso(miso)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int half_of(input logic [7:0] d);
    return (d < 2) ? 1 : int'(d) / 2;
  endfunction

  function automatic int lead_of(input logic dly, input logic sf);
    return !dly ? 1 : (sf ? 2 : 3);
  endfunction

  function automatic int n_of(input logic [5:0] len);
    return (len == 0) ? 1 : (len > 32) ? 32 : int'(len);
  endfunction

  function automatic logic [31:0] mask_of(input int n);
    return (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic slave_bit(input vec_t v, input int k, input int n);
    return v.lsb ? v.sw[k] : v.sw[n-1-k];
  endfunction

  task automatic apply_cfg(input vec_t v);
    cfg_div = v.div; cfg_cap_fall = v.cap; cfg_idle_high = v.idle;
    cfg_start_dly = v.dly; cfg_start_fall = v.sf; cfg_frame_high = v.fp;
    cfg_lsb_first = v.lsb; cfg_len = v.len;
  endtask

  task automatic run_word(input vec_t v);
    int h, l, n;
    int act_cnt = 0, lead_cnt = -1, edges = 0, rv_cnt = 0, rv_bad = 0;
    int busy_bad = 0, ready_bad = 0, idx = 0, tail = 0;
    logic prev_sclk, prev_mosi;
    logic [31:0] got = '0, rxw = '0, mask;
    bit finished = 0;
    h = half_of(v.div); l = lead_of(v.dly, v.sf); n = n_of(v.len);
    mask = mask_of(n);
    @(negedge clk);
    apply_cfg(v);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", "idle sclk level", sclk, v.idle);
    chk("R5", "fsel inactive before word", fsel, !v.fp);
    chk("R8", "tx_ready when idle", tx_ready, 1);
    miso = slave_bit(v, 0, n);
    tx_data = v.tx; tx_valid = 1'b1;
    prev_sclk = sclk; prev_mosi = mosi;
    for (int k = 1; k < 5000 && !finished; k++) begin
      @(negedge clk);
      if (k == 1) begin tx_valid = 1'b0; tx_data = '0; end
      if (fsel == v.fp) begin
        act_cnt++;
        if (!busy) busy_bad++;
        if (tx_ready) ready_bad++;
      end
      if (sclk != prev_sclk) begin
        edges++;
        if (edges == 1) lead_cnt = act_cnt - 1;
        if (prev_sclk == v.cap) begin
          if (idx < n) begin
            if (v.lsb) got[idx] = prev_mosi; else got[n-1-idx] = prev_mosi;
          end
          idx++;
          miso = (idx < n) ? slave_bit(v, idx, n) : 1'b0;
        end
      end
      if (rx_valid) begin
        rv_cnt++;
        rxw = rx_data;
        if (fsel == v.fp || busy) rv_bad++;
      end
      prev_sclk = sclk; prev_mosi = mosi;
      if (rv_cnt > 0) tail++;
      if (tail > 3) finished = 1;
    end
    chk("R1",  "frame length in cycles", act_cnt, h * (l + 2 * n));
    chk("R3",  "cycles to first edge", lead_cnt, h * l);
    chk("R11", "serial clock edges", edges, 2 * n);
    chk("R11", "sclk back at idle", sclk, v.idle);
    chk("R6",  "bits seen by slave", got, v.tx & mask);
    chk("R4",  "received word", rxw & mask, v.sw & mask);
    chk("R7",  "upper rx bits zero", rxw & ~mask, 0);
    chk("R10", "rx_valid pulse count", rv_cnt, 1);
    chk("R10", "rx_valid with frame closed", rv_bad, 0);
    chk("R8",  "busy/ready during frame", busy_bad + ready_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    vec_t ab;
    int rv_seen;
    rst_n = 1'b0; enable = 1'b0; tx_valid = 1'b0; tx_data = '0; miso = 1'b0;
    apply_cfg(VECS[0]);
    cfg_frame_high = 1'b1;
    repeat (3) @(negedge clk);
    // Reset state
    chk("R8",  "busy in reset", busy, 0);
    chk("R10", "rx_valid in reset", rx_valid, 0);
    chk("R5",  "fsel inactive in reset", fsel, 0);
    chk("R8",  "tx_ready with enable low", tx_ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Enable low: offered word is ignored
    tx_valid = 1'b1; tx_data = 32'h0000_00FF;
    rv_seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (busy || fsel != 1'b0 || rx_valid) rv_seen++;
    end
    tx_valid = 1'b0;
    chk("R9", "word ignored while disabled", rv_seen, 0);
    chk("R9", "tx_ready low while disabled", tx_ready, 0);

    // Table of vectors
    foreach (VECS[i]) run_word(VECS[i]);

    // Abort in mid-word
    ab = VECS[0];
    ab.div = 8'd20;
    @(negedge clk);
    apply_cfg(ab);
    enable = 1'b1;
    repeat (2) @(negedge clk);
    tx_data = ab.tx; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk("R8", "busy mid-word", busy, 1);
    enable = 1'b0;
    @(negedge clk);
    chk("R9", "busy after abort", busy, 0);
    chk("R9", "fsel after abort", fsel, !ab.fp);
    chk("R9", "sclk after abort", sclk, ab.idle);
    rv_seen = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (rx_valid) rv_seen++;
    end
    chk("R9", "no rx_valid after abort", rv_seen, 0);

    // Recovery after abort
    run_word(VECS[3]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule